// File: doc/BRIEF.md
# I2C Master Byte Mover

This block feeds data bytes to an I2C master sequencer and stores the bytes the sequencer collects. For each command it picks one of three sources or sinks: a single holding register, a small shared byte pool indexed by a per-command position, or an external memory reached through a request/acknowledge port with a running address and remaining length. The sequencer asks for one byte at a time on the transmit side (and reports ACK or NAK), or hands over one byte at a time on the receive side.

Software sets up four configuration registers through a simple select/write port, then issues a command naming the direction, whether a start condition already carried the address byte, and which storage to use. The block walks the transfer byte by byte, updates its counters, and ends with a one-cycle completion pulse carrying NAK and memory-error flags. Commands that need shared storage are turned away while the global storage enable is low, and a memory command is turned away when the remaining length is zero.

Top module: `byte_mover`

## Requirements
- R1: After reset all four configuration registers and the zero-length flag read zero, and no transmit, receive or memory request is raised.
- R2: A write with cfg_sel=0 replaces only bits 23:0 of pool_ctrl; bits 31:24 keep their value. In pool_ctrl, bits 13:9 hold the transmit count, bits 20:16 the receive size and bits 28:24 the receive result count.
- R3: A write with cfg_sel=1 changes only byte_buf[7:0]. A holding-register transmit sends byte_buf[7:0]; a holding-register receive stores the byte in byte_buf[15:8].
- R4: When a command asks for several storages, pool wins over memory, and memory over the holding register; only one is used for the transfer.
- R5: A pool transmit sends pool entries from a first index up to transmit count minus 1, where the first index is 1 if cmd_start is set and 0 otherwise; if the first index is not below the count, no byte is sent and the command completes.
- R6: A pool transmit stops at the first NAK and completes with done_nak set.
- R7: A pool receive writes receive-size bytes into pool entries 0 upward, then sets pool_ctrl[28:24] to the number received.
- R8: A write with cfg_sel=2 stores the data ANDed with 0x3FFFFFFC in dma_addr; a write with cfg_sel=3 keeps the low 12 bits in dma_len.
- R9: In memory mode each byte moved increments dma_addr by one and decrements dma_len by one; a transmit reads the memory before offering the byte, and the transfer completes when dma_len reaches zero.
- R10: A memory error ends the transfer at once with done_err set; the failed byte leaves dma_addr and dma_len unchanged and no further byte is requested.
- R11: While sram_en is low, a command with cmd_pool or cmd_dma set is refused with a cmd_reject pulse and moves no byte; holding-register commands are still accepted.
- R12: Writing zero to dma_len sets len_zero and a non-zero write clears it; a memory-mode command issued while dma_len is zero is refused with cmd_reject.
- R13: Configuration writes arriving while a transfer is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sram_en | input | 1 | Global enable for pool and memory modes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 pool_ctrl, 1 byte_buf, 2 dma_addr, 3 dma_len |
| cfg_wdata | input | 32 | Configuration write data |
| cmd_valid | input | 1 | Command strobe, honoured only while idle |
| cmd_rx | input | 1 | 1 receive, 0 transmit |
| cmd_start | input | 1 | A start has already sent pool entry 0 as the address |
| cmd_pool | input | 1 | Use the byte pool |
| cmd_dma | input | 1 | Use external memory |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_nak | output | 1 | With done: transfer ended on a NAK |
| done_err | output | 1 | With done: transfer ended on a memory error |
| cmd_reject | output | 1 | One-cycle pulse: command refused |
| tx_req | output | 1 | Byte offered to the sequencer |
| tx_data | output | 8 | Byte offered |
| tx_done | input | 1 | Sequencer has sent the byte |
| tx_nak | input | 1 | With tx_done: the byte was not acknowledged |
| rx_req | output | 1 | Byte wanted from the sequencer |
| rx_done | input | 1 | Sequencer delivers a byte |
| rx_data | input | 8 | Delivered byte |
| pool_addr | output | 5 | Pool entry index (combinational read) |
| pool_we | output | 1 | Pool write strobe |
| pool_wdata | output | 8 | Pool write data |
| pool_rdata | input | 8 | Pool read data for pool_addr |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access finished |
| mem_err | input | 1 | With mem_ack: access failed |
| pool_ctrl | output | 32 | Pool count register |
| byte_buf | output | 16 | Holding register: transmit byte low, received byte high |
| dma_addr | output | AW | Memory address register |
| dma_len | output | LEN_W | Remaining memory byte count |
| len_zero | output | 1 | Last dma_len write was zero |

## Verification
The embedded properties assume a sequencer and memory that answer only while the matching request is high, with a single-cycle tx_done, rx_done or mem_ack per request, and that cmd_valid is a single-cycle strobe. The bench responders wait for a request that has not yet been answered, answer it at the falling edge for exactly one cycle and then stay quiet until the request is seen again, so every handshake stays inside that contract. Memory faults are injected only at one chosen address, and configuration writes during a transfer are placed several cycles after the command so that the block is certain to be busy.

// File: rtl/byte_mover.sv
module byte_mover #(
  parameter int AW    = 32,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sram_en,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             cmd_valid,
  input  logic             cmd_rx,
  input  logic             cmd_start,
  input  logic             cmd_pool,
  input  logic             cmd_dma,
  output logic             busy,
  output logic             done,
  output logic             done_nak,
  output logic             done_err,
  output logic             cmd_reject,
  output logic             tx_req,
  output logic [7:0]       tx_data,
  input  logic             tx_done,
  input  logic             tx_nak,
  output logic             rx_req,
  input  logic             rx_done,
  input  logic [7:0]       rx_data,
  output logic [4:0]       pool_addr,
  output logic             pool_we,
  output logic [7:0]       pool_wdata,
  input  logic [7:0]       pool_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  output logic [31:0]      pool_ctrl,
  output logic [15:0]      byte_buf,
  output logic [AW-1:0]    dma_addr,
  output logic [LEN_W-1:0] dma_len,
  output logic             len_zero
);
  localparam int CW = 5;
  localparam logic [AW-1:0] AMASK = {2'b00, {(AW-4){1'b1}}, 2'b00};

  typedef enum logic [2:0] {S_IDLE, S_TX, S_RX, S_MRD, S_MWR} st_t;
  typedef enum logic [1:0] {M_BYTE, M_POOL, M_DMA} md_t;

  st_t st;
  md_t md;
  logic [CW-1:0] idx;
  logic [7:0]    hold;

  wire [CW-1:0] txcnt    = pool_ctrl[13:9];
  wire [CW-1:0] rxsz     = pool_ctrl[20:16];
  wire          idle     = (st == S_IDLE);
  wire          bad_sram = (cmd_pool | cmd_dma) & ~sram_en;
  wire          bad_len  = ~cmd_pool & cmd_dma & (dma_len == '0);
  wire          accept   = idle & cmd_valid & ~bad_sram & ~bad_len;
  wire [CW-1:0] idx_n    = idx + 1'b1;
  wire [CW-1:0] tx_first = cmd_start ? CW'(1) : CW'(0);

  assign busy       = ~idle;
  assign tx_req     = (st == S_TX);
  assign tx_data    = (md == M_POOL) ? pool_rdata : hold;
  assign rx_req     = (st == S_RX);
  assign pool_addr  = idx;
  assign pool_we    = (st == S_RX) & rx_done & (md == M_POOL);
  assign pool_wdata = rx_data;
  assign mem_req    = (st == S_MRD) | (st == S_MWR);
  assign mem_we     = (st == S_MWR);
  assign mem_addr   = dma_addr;
  assign mem_wdata  = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; md <= M_BYTE; idx <= '0; hold <= '0;
      pool_ctrl <= '0; byte_buf <= '0; dma_addr <= '0; dma_len <= '0; len_zero <= 1'b0;
      done <= 1'b0; done_nak <= 1'b0; done_err <= 1'b0; cmd_reject <= 1'b0;
    end else begin
      done <= 1'b0; done_nak <= 1'b0; done_err <= 1'b0; cmd_reject <= 1'b0;
      if (idle && cfg_we) begin
        case (cfg_sel)
          2'd0: pool_ctrl[23:0] <= cfg_wdata[23:0];
          2'd1: byte_buf[7:0]   <= cfg_wdata[7:0];
          2'd2: dma_addr        <= cfg_wdata[AW-1:0] & AMASK;
          default: begin
            dma_len  <= cfg_wdata[LEN_W-1:0];
            len_zero <= (cfg_wdata[LEN_W-1:0] == '0);
          end
        endcase
      end
      case (st)
        S_IDLE: begin
          if (cmd_valid && !accept) cmd_reject <= 1'b1;
          else if (accept) begin
            md <= cmd_pool ? M_POOL : (cmd_dma ? M_DMA : M_BYTE);
            if (cmd_pool) begin
              if (cmd_rx) begin
                idx <= '0;
                if (rxsz == '0) begin pool_ctrl[28:24] <= '0; done <= 1'b1; end
                else st <= S_RX;
              end else begin
                idx <= tx_first;
                if (tx_first >= txcnt) done <= 1'b1;
                else st <= S_TX;
              end
            end else if (cmd_dma) begin
              st <= cmd_rx ? S_RX : S_MRD;
            end else begin
              hold <= byte_buf[7:0];
              st   <= cmd_rx ? S_RX : S_TX;
            end
          end
        end
        S_TX: if (tx_done) begin
          if (tx_nak) begin
            st <= S_IDLE; done <= 1'b1; done_nak <= 1'b1;
          end else begin
            case (md)
              M_POOL: begin
                idx <= idx_n;
                if (idx_n >= txcnt) begin st <= S_IDLE; done <= 1'b1; end
              end
              M_DMA: if (dma_len == '0) begin st <= S_IDLE; done <= 1'b1; end
                     else st <= S_MRD;
              default: begin st <= S_IDLE; done <= 1'b1; end
            endcase
          end
        end
        S_MRD: if (mem_ack) begin
          if (mem_err) begin
            st <= S_IDLE; done <= 1'b1; done_err <= 1'b1;
          end else begin
            hold     <= mem_rdata;
            dma_addr <= dma_addr + 1'b1;
            dma_len  <= dma_len - 1'b1;
            st       <= S_TX;
          end
        end
        S_RX: if (rx_done) begin
          case (md)
            M_POOL: begin
              idx <= idx_n;
              if (idx_n >= rxsz) begin
                pool_ctrl[28:24] <= idx_n;
                st <= S_IDLE; done <= 1'b1;
              end
            end
            M_DMA: begin hold <= rx_data; st <= S_MWR; end
            default: begin byte_buf[15:8] <= rx_data; st <= S_IDLE; done <= 1'b1; end
          endcase
        end
        S_MWR: if (mem_ack) begin
          if (mem_err) begin
            st <= S_IDLE; done <= 1'b1; done_err <= 1'b1;
          end else begin
            dma_addr <= dma_addr + 1'b1;
            dma_len  <= dma_len - 1'b1;
            if (dma_len == LEN_W'(1)) begin st <= S_IDLE; done <= 1'b1; end
            else st <= S_RX;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_one_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_req, rx_req, mem_req}));

  p_pool_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && md == M_POOL) |-> (pool_addr < txcnt));

  p_refuse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_valid && (cmd_pool || cmd_dma) && !sram_en) |=> (!busy && cmd_reject));

  p_dma_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MRD && mem_ack && !mem_err) |=>
      (dma_len == $past(dma_len) - 1'b1 && dma_addr == $past(dma_addr) + 1'b1));

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> ($stable(dma_addr) && $stable(dma_len) && done_err && !busy));

  p_addr_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cfg_we && cfg_sel == 2'd2) |=> (dma_addr[1:0] == 2'b00 && dma_addr[AW-1:AW-2] == 2'b00));

  p_busy_cfg_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && cfg_sel == 2'd1) |=> $stable(byte_buf[7:0]));
endmodule

// File: tb/sim_byte_mover.sv
module sim_byte_mover;
  logic clk = 0, rst_n = 0, sram_en = 0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
  logic cmd_valid = 0, cmd_rx = 0, cmd_start = 0, cmd_pool = 0, cmd_dma = 0;
  logic busy, done, done_nak, done_err, cmd_reject;
  logic tx_req; logic [7:0] tx_data; logic tx_done = 0, tx_nak = 0;
  logic rx_req, rx_done = 0; logic [7:0] rx_data = 0;
  logic [4:0] pool_addr; logic pool_we; logic [7:0] pool_wdata, pool_rdata;
  logic mem_req, mem_we; logic [31:0] mem_addr; logic [7:0] mem_wdata, mem_rdata = 0;
  logic mem_ack = 0, mem_err = 0;
  logic [31:0] pool_ctrl, dma_addr; logic [15:0] byte_buf; logic [11:0] dma_len; logic len_zero;

  always #10 clk = ~clk;

  byte_mover u0 (.*);

  logic [7:0] pool_mem [32];
  logic [7:0] ext_mem [256];
  assign pool_rdata = pool_mem[pool_addr];
  always @(posedge clk) if (pool_we) pool_mem[pool_addr] <= pool_wdata;

  int checks = 0, fails = 0;
  int nak_at = -1;
  bit err_on = 0; logic [31:0] err_addr = 0;
  int rx_ctr = 0;
  logic [7:0] txq[$], rxq[$];
  logic [31:0] m_pctl = 0, m_daddr = 0; logic [15:0] m_bbuf = 0; logic [11:0] m_dlen = 0; bit m_lz = 0;
  bit live = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  initial forever begin
    @(negedge clk);
    if (tx_req && !tx_done) begin
      tx_nak = (txq.size() == nak_at); txq.push_back(tx_data); tx_done = 1;
    end else begin tx_done = 0; tx_nak = 0; end
    if (rx_req && !rx_done) begin
      rx_data = 8'h50 + 8'(rx_ctr); rx_ctr++; rxq.push_back(rx_data); rx_done = 1;
    end else rx_done = 0;
    if (mem_req && !mem_ack) begin
      mem_ack = 1; mem_err = err_on && (mem_addr == err_addr);
      if (!mem_err) begin
        if (mem_we) ext_mem[mem_addr[7:0]] = mem_wdata;
        else mem_rdata = ext_mem[mem_addr[7:0]];
      end
    end else begin mem_ack = 0; mem_err = 0; end
  end

  initial forever begin
    @(negedge clk); #1;
    if (live && !busy) begin
      chk(pool_ctrl == m_pctl, "R2 pool_ctrl", pool_ctrl, m_pctl);
      chk(byte_buf == m_bbuf, "R3 byte_buf", 32'(byte_buf), 32'(m_bbuf));
      chk(dma_addr == m_daddr, "R9 dma_addr", dma_addr, m_daddr);
      chk(dma_len == m_dlen, "R9 dma_len", 32'(dma_len), 32'(m_dlen));
      chk(len_zero == m_lz, "R12 len_zero", 32'(len_zero), 32'(m_lz));
    end
  end

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d, input bit apply);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (apply) case (sel)
      2'd0: m_pctl = (m_pctl & 32'hFF000000) | (d & 32'h00FFFFFF);
      2'd1: m_bbuf[7:0] = d[7:0];
      2'd2: m_daddr = d & 32'h3FFFFFFC;
      default: begin m_dlen = d[11:0]; m_lz = (d[11:0] == 0); end
    endcase
  endtask

  task automatic run(input bit rx, st, pl, dm, output bit rej, nak, er);
    txq.delete(); rxq.delete();
    @(negedge clk); cmd_rx = rx; cmd_start = st; cmd_pool = pl; cmd_dma = dm; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    rej = cmd_reject; nak = 0; er = 0;
    if (!rej) begin
      for (int n = 0; !done && n < 2000; n++) @(negedge clk);
      nak = done_nak; er = done_err;
    end
  endtask

  task automatic chk_tx(string req, logic [7:0] exp[$]);
    chk(txq.size() == exp.size(), req, txq.size(), exp.size());
    foreach (exp[i]) if (i < txq.size()) chk(txq[i] == exp[i], req, txq[i], exp[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit rej, nak, er;
    for (int i = 0; i < 32; i++) pool_mem[i] = 8'(i * 3 + 1);
    for (int i = 0; i < 256; i++) ext_mem[i] = 8'(i) ^ 8'h5A;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!busy && !tx_req && !rx_req && !mem_req, "R1 idle", {busy, tx_req, rx_req, mem_req}, 0);
    chk(pool_ctrl == 0 && byte_buf == 0 && dma_addr == 0 && dma_len == 0 && !len_zero,
        "R1 regs", pool_ctrl | 32'(byte_buf) | dma_addr, 0);
    live = 1;

    cfg(2'd1, 32'h1234, 1);
    chk(byte_buf == 16'h0034, "R3 tx byte write", 32'(byte_buf), 32'h34);
    run(0, 0, 0, 0, rej, nak, er);
    chk(!rej && !nak, "R11 byte mode with storage off", {rej, nak}, 0);
    chk_tx("R3 byte tx", '{8'h34});
    run(1, 0, 0, 0, rej, nak, er);
    chk(rxq.size() == 1, "R3 byte rx count", rxq.size(), 1);
    m_bbuf[15:8] = rxq[0];
    chk(byte_buf[15:8] == rxq[0], "R3 byte rx store", 32'(byte_buf[15:8]), 32'(rxq[0]));

    cfg(2'd0, 32'(4 << 9), 1);
    run(0, 0, 1, 0, rej, nak, er);
    chk(rej && txq.size() == 0, "R11 pool refused", txq.size(), 0);
    cfg(2'd3, 32'd2, 1);
    run(1, 0, 0, 1, rej, nak, er);
    chk(rej && rxq.size() == 0, "R11 dma refused", rxq.size(), 0);

    sram_en = 1;
    run(0, 1, 1, 0, rej, nak, er);
    chk_tx("R5 pool tx after start", '{pool_mem[1], pool_mem[2], pool_mem[3]});
    run(0, 0, 1, 0, rej, nak, er);
    chk_tx("R5 pool tx from zero", '{pool_mem[0], pool_mem[1], pool_mem[2], pool_mem[3]});
    cfg(2'd0, 32'(1 << 9), 1);
    run(0, 1, 1, 0, rej, nak, er);
    chk(!rej && txq.size() == 0, "R5 nothing after address", txq.size(), 0);

    cfg(2'd0, 32'(4 << 9), 1);
    nak_at = 1;
    run(0, 0, 1, 0, rej, nak, er);
    nak_at = -1;
    chk(nak, "R6 nak flag", nak, 1);
    chk_tx("R6 stop at nak", '{pool_mem[0], pool_mem[1]});

    cfg(2'd0, (32'd3 << 16) | 32'(4 << 9), 1);
    run(1, 0, 1, 0, rej, nak, er);
    m_pctl[28:24] = 5'd3;
    chk(rxq.size() == 3, "R7 rx bytes", rxq.size(), 3);
    for (int i = 0; i < 3; i++) chk(pool_mem[i] == rxq[i], "R7 pool store", pool_mem[i], rxq[i]);
    chk(pool_ctrl[28:24] == 3, "R7 rx count", 32'(pool_ctrl[28:24]), 3);

    cfg(2'd0, 32'hFFFFFFFF, 1);
    chk(pool_ctrl == 32'h03FFFFFF, "R2 low bits only", pool_ctrl, 32'h03FFFFFF);
    cfg(2'd0, 32'(4 << 9), 1);

    cfg(2'd2, 32'hFFFFFFFF, 1);
    chk(dma_addr == 32'h3FFFFFFC, "R8 addr mask", dma_addr, 32'h3FFFFFFC);
    cfg(2'd3, 32'h12345, 1);
    chk(dma_len == 12'h345, "R8 len mask", 32'(dma_len), 32'h345);

    cfg(2'd2, 32'h10, 1); cfg(2'd3, 32'd3, 1);
    run(0, 0, 0, 1, rej, nak, er);
    m_daddr = 32'h13; m_dlen = 0;
    chk_tx("R9 dma tx", '{ext_mem[16], ext_mem[17], ext_mem[18]});
    chk(dma_addr == 32'h13 && dma_len == 0, "R9 counters", dma_addr, 32'h13);

    cfg(2'd2, 32'h20, 1); cfg(2'd3, 32'd2, 1);
    run(0, 0, 1, 1, rej, nak, er);
    chk_tx("R4 pool over dma", '{pool_mem[0], pool_mem[1], pool_mem[2], pool_mem[3]});
    run(0, 0, 0, 1, rej, nak, er);
    m_daddr = 32'h22; m_dlen = 0;
    chk_tx("R4 dma over byte", '{ext_mem[32], ext_mem[33]});

    cfg(2'd2, 32'h40, 1); cfg(2'd3, 32'd3, 1);
    err_on = 1; err_addr = 32'h41;
    run(1, 0, 0, 1, rej, nak, er);
    err_on = 0;
    m_daddr = 32'h41; m_dlen = 2;
    chk(er, "R10 error flag", er, 1);
    chk(rxq.size() == 2, "R10 no more bytes", rxq.size(), 2);
    chk(ext_mem[8'h40] == rxq[0], "R10 first byte stored", ext_mem[8'h40], rxq[0]);
    chk(dma_addr == 32'h41 && dma_len == 2, "R10 counters held", dma_addr, 32'h41);

    cfg(2'd3, 32'd0, 1);
    chk(len_zero, "R12 flag set", len_zero, 1);
    run(0, 0, 0, 1, rej, nak, er);
    chk(rej && txq.size() == 0, "R12 zero length refused", rej, 1);
    cfg(2'd3, 32'd1, 1);
    chk(!len_zero, "R12 flag cleared", len_zero, 0);

    cfg(2'd2, 32'h60, 1); cfg(2'd3, 32'd4, 1);
    fork
      run(1, 0, 0, 1, rej, nak, er);
      begin repeat (3) @(negedge clk); cfg(2'd1, 32'hEE, 0); end
    join
    m_daddr = 32'h64; m_dlen = 0;
    chk(byte_buf[7:0] == 8'h34, "R13 busy write ignored", 32'(byte_buf[7:0]), 32'h34);
    for (int i = 0; i < 4; i++)
      if (i < rxq.size()) chk(ext_mem[8'h60 + i] == rxq[i], "R9 dma rx store", ext_mem[8'h60 + i], rxq[i]);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule